// File: doc/BRIEF.md
# Shared Pin Multiplexer

This block resolves five device pads that a SPI-style serial port and two multichannel audio serial ports share. Each peripheral presents an output enable and an output value for each pad it can reach. The block works out whether each pad drives, and which value it drives. Every pad's sampled level goes back to the audio ports unchanged. The SPI receives a pad's level only where the current mode gives that pad to the SPI.

A small configuration register sets the SPI pin mode, from all five pins down to no pins. The mode decides which pads belong to the SPI. A pad the SPI does not hold becomes an audio data pad, which changes how many data pins each audio port can use. When the SPI is off, two owner bits choose which audio port uses each of the two dual-use pads.

Collisions are allowed. A pad drives if any remaining enable is set, and a fixed order picks the value. A sticky per-pad flag records every collision until it is cleared by a write.

Top module: `pinmux_shared_pins`

## Requirements
- R1: After a synchronous reset:
  - the mode is off (code 4);
  - both owner bits are 0;
  - all conflict flags are clear;
  - aud0_width reads 16 and aud1_width reads 4.
- R2: pad_oe for a pad is the OR of the enables left after masking (R6, R7). An audio enable on pads 0 to 2 is never masked.
- R3: A driven pad takes its value from the first enabled source in the order SPI, first audio port, second audio port. A pad with no enable outputs 0.
- R4: aud0_in equals pad_in on every cycle. aud1_in bit 0 equals pad 3 and aud1_in bit 1 equals pad 4, whichever source is driving.
- R5: Pads are ordered 0 chip-select, 1 enable, 2 clock, 3 slave-out, 4 slave-in. The mode codes grant the SPI these pads:
  - code 0 grants all five;
  - code 1 grants pads 0, 2, 3 and 4;
  - code 2 grants pads 1 to 4;
  - code 3 grants pads 2 to 4;
  - code 4 grants none.
  
  On a granted pad, spi_in carries the pad level.
- R6: On a pad not granted to the SPI, the SPI enable and value have no effect on pad_oe, pad_out or the conflict flags. On such a pad, spi_in shows an idle level: 1 on pads 0 and 1, and 0 on pads 2 to 4.
- R7: In the off mode, owner bit 0 (pad 3) and owner bit 1 (pad 4) select the second audio port when 1 and the first audio port when 0. The enable of the port that does not own the pad is ignored. In the other modes neither audio port is masked.
- R8: A conflict flag sets on the cycle after two or more enables remaining after masking are active on its pad. It stays set until cleared. A write to address 1 clears the flags whose wr_data bits are 1. A new conflict in the same cycle wins over the clear.
- R9: A write to address 0 loads the mode from data bits 2:0 and the owner bits from data bits 4:3. It takes effect on the next cycle. Codes 5 to 7 behave exactly as the off mode.
- R10: aud0_width is:
  - 11 plus the number of pads 0 to 2 not granted to the SPI;
  - plus, in the off mode, the number of dual-use pads owned by the first port.
  
  aud1_width is 4 plus, in the off mode, the number of dual-use pads owned by the second port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 1 | 0 = mode/owner register, 1 = conflict clear |
| cfg_wr_data | input | 5 | Write data |
| spi_oe | input | 5 | SPI per-pad output enable |
| spi_out | input | 5 | SPI per-pad output value |
| spi_in | output | 5 | Pad level or idle level seen by the SPI |
| aud0_oe | input | 5 | First audio port enables (data 5 to 9 on pads 0 to 4) |
| aud0_out | input | 5 | First audio port values |
| aud0_in | output | 5 | Pad levels to the first audio port |
| aud1_oe | input | 2 | Second audio port enables (bit 0 data 5 on pad 3, bit 1 data 4 on pad 4) |
| aud1_out | input | 2 | Second audio port values |
| aud1_in | output | 2 | Pad levels to the second audio port |
| pad_in | input | 5 | Sampled pad levels |
| pad_oe | output | 5 | Resolved pad output enable |
| pad_out | output | 5 | Resolved pad output value |
| conflict | output | 5 | Sticky per-pad collision flags |
| aud0_width | output | 5 | Data pins usable by the first audio port |
| aud1_width | output | 5 | Data pins usable by the second audio port |

## Verification
The hardest case to reach is a three-way collision on a dual-use pad that lands in the same cycle as a clear of that pad's flag, while a mode is active in which the SPI still owns the pad. Owner masking in the off mode would otherwise remove one of the drivers. The stimulus walks through all eight mode codes and all four owner combinations. In each setting it applies biased random enables, so that collisions on the same pad are common. Clear writes with random masks are issued on about a quarter of the cycles, so that set-versus-clear overlaps happen repeatedly in every mode.

// File: rtl/pinmux_pkg.sv
`timescale 1ns/1ps
package pinmux_pkg;
  localparam int NPAD     = 5;
  localparam int NDUAL    = 2;
  localparam int DUAL_LO  = 3;
  localparam int MODE_W   = 3;
  localparam int CFG_W    = MODE_W + NDUAL;

  localparam logic [MODE_W-1:0] MODE_FIVE   = 3'd0;
  localparam logic [MODE_W-1:0] MODE_NO_ENA = 3'd1;
  localparam logic [MODE_W-1:0] MODE_NO_CS  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_THREE  = 3'd3;
  localparam logic [MODE_W-1:0] MODE_OFF    = 3'd4;

  // idle levels given to the SPI on pads it does not hold
  localparam logic [NPAD-1:0] SPI_IDLE = 5'b00011;
endpackage

// File: rtl/pinmux_cfg_regs.sv
`timescale 1ns/1ps
module pinmux_cfg_regs
  import pinmux_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [NPAD-1:0]   hit,
  output logic [MODE_W-1:0] mode,
  output logic [NDUAL-1:0]  owner,
  output logic [NPAD-1:0]   conflict
);
  logic wr_cfg, wr_clr;
  assign wr_cfg = wr_en && !wr_addr;
  assign wr_clr = wr_en &&  wr_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= MODE_OFF;
      owner <= '0;
    end else if (wr_cfg) begin
      mode  <= wr_data[MODE_W-1:0];
      owner <= wr_data[CFG_W-1:MODE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) conflict <= '0;
    else if (wr_clr) conflict <= (conflict & ~wr_data[NPAD-1:0]) | hit;
    else conflict <= conflict | hit;
  end
endmodule

// File: rtl/pinmux_owner_map.sv
`timescale 1ns/1ps
module pinmux_owner_map
  import pinmux_pkg::*;
#(
  parameter int AUD0_BASE = 11,
  parameter int AUD1_BASE = 4,
  parameter int CNT_W     = 5
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [NDUAL-1:0]  owner,
  output logic [NPAD-1:0]   spi_grant,
  output logic [NPAD-1:0]   aud0_keep,
  output logic [NDUAL-1:0]  aud1_keep,
  output logic [CNT_W-1:0]  aud0_width,
  output logic [CNT_W-1:0]  aud1_width
);
  logic off;

  always_comb begin
    case (mode)
      MODE_FIVE:   spi_grant = 5'b11111;
      MODE_NO_ENA: spi_grant = 5'b11101;
      MODE_NO_CS:  spi_grant = 5'b11110;
      MODE_THREE:  spi_grant = 5'b11100;
      default:     spi_grant = 5'b00000;
    endcase
  end

  assign off = (spi_grant == '0);

  always_comb begin
    aud0_keep = '1;
    aud1_keep = '1;
    if (off) begin
      for (int d = 0; d < NDUAL; d++) begin
        aud0_keep[DUAL_LO+d] = !owner[d];
        aud1_keep[d]         =  owner[d];
      end
    end
  end

  always_comb begin
    aud0_width = CNT_W'(AUD0_BASE);
    aud1_width = CNT_W'(AUD1_BASE);
    for (int p = 0; p < DUAL_LO; p++)
      if (!spi_grant[p]) aud0_width = aud0_width + CNT_W'(1);
    if (off) begin
      for (int d = 0; d < NDUAL; d++) begin
        if (owner[d]) aud1_width = aud1_width + CNT_W'(1);
        else          aud0_width = aud0_width + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pinmux_pad_resolve.sv
`timescale 1ns/1ps
module pinmux_pad_resolve
  import pinmux_pkg::*;
(
  input  logic [NPAD-1:0] s_oe,
  input  logic [NPAD-1:0] s_val,
  input  logic [NPAD-1:0] a_oe,
  input  logic [NPAD-1:0] a_val,
  input  logic [NPAD-1:0] b_oe,
  input  logic [NPAD-1:0] b_val,
  output logic [NPAD-1:0] pad_oe,
  output logic [NPAD-1:0] pad_out,
  output logic [NPAD-1:0] hit
);
  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    logic [1:0] n_en;
    always_comb begin
      n_en = {1'b0, s_oe[p]} + {1'b0, a_oe[p]} + {1'b0, b_oe[p]};
      if      (s_oe[p]) pad_out[p] = s_val[p];
      else if (a_oe[p]) pad_out[p] = a_val[p];
      else if (b_oe[p]) pad_out[p] = b_val[p];
      else              pad_out[p] = 1'b0;
    end
    assign pad_oe[p] = s_oe[p] | a_oe[p] | b_oe[p];
    assign hit[p]    = n_en[1];
  end
endmodule

// File: rtl/pinmux_shared_pins.sv
`timescale 1ns/1ps
module pinmux_shared_pins
  import pinmux_pkg::*;
#(
  parameter int AUD0_BASE = 11,
  parameter int AUD1_BASE = 4,
  parameter int CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic              cfg_wr_addr,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  input  logic [NPAD-1:0]   spi_oe,
  input  logic [NPAD-1:0]   spi_out,
  output logic [NPAD-1:0]   spi_in,
  input  logic [NPAD-1:0]   aud0_oe,
  input  logic [NPAD-1:0]   aud0_out,
  output logic [NPAD-1:0]   aud0_in,
  input  logic [NDUAL-1:0]  aud1_oe,
  input  logic [NDUAL-1:0]  aud1_out,
  output logic [NDUAL-1:0]  aud1_in,
  input  logic [NPAD-1:0]   pad_in,
  output logic [NPAD-1:0]   pad_oe,
  output logic [NPAD-1:0]   pad_out,
  output logic [NPAD-1:0]   conflict,
  output logic [CNT_W-1:0]  aud0_width,
  output logic [CNT_W-1:0]  aud1_width
);
  logic [MODE_W-1:0] cfg_mode;
  logic [NDUAL-1:0]  cfg_owner;
  logic [NPAD-1:0]   spi_grant, aud0_keep, hit;
  logic [NDUAL-1:0]  aud1_keep;
  logic [NPAD-1:0]   s_oe_m, s_val_m, a_oe_m, b_oe_x, b_val_x;

  pinmux_cfg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .hit(hit), .mode(cfg_mode), .owner(cfg_owner),
    .conflict(conflict)
  );

  pinmux_owner_map #(.AUD0_BASE(AUD0_BASE), .AUD1_BASE(AUD1_BASE), .CNT_W(CNT_W)) u_map (
    .mode(cfg_mode), .owner(cfg_owner), .spi_grant(spi_grant),
    .aud0_keep(aud0_keep), .aud1_keep(aud1_keep),
    .aud0_width(aud0_width), .aud1_width(aud1_width)
  );

  assign s_oe_m  = spi_oe  & spi_grant;
  assign s_val_m = spi_out & spi_grant;
  assign a_oe_m  = aud0_oe & aud0_keep;

  for (genvar p = 0; p < NPAD; p++) begin : g_b
    if (p >= DUAL_LO && p < DUAL_LO + NDUAL) begin : g_dual
      assign b_oe_x[p]  = aud1_oe[p-DUAL_LO] & aud1_keep[p-DUAL_LO];
      assign b_val_x[p] = aud1_out[p-DUAL_LO];
      assign aud1_in[p-DUAL_LO] = pad_in[p];
    end else begin : g_none
      assign b_oe_x[p]  = 1'b0;
      assign b_val_x[p] = 1'b0;
    end
  end

  pinmux_pad_resolve u_res (
    .s_oe(s_oe_m), .s_val(s_val_m), .a_oe(a_oe_m), .a_val(aud0_out),
    .b_oe(b_oe_x), .b_val(b_val_x), .pad_oe(pad_oe), .pad_out(pad_out), .hit(hit)
  );

  assign aud0_in = pad_in;
  assign spi_in  = (pad_in & spi_grant) | (SPI_IDLE & ~spi_grant);
endmodule

// File: rtl/pinmux_shared_pins_chk.sv
`timescale 1ns/1ps
module pinmux_shared_pins_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_wr_en,
  input logic       cfg_wr_addr,
  input logic [4:0] cfg_wr_data,
  input logic [2:0] mode,
  input logic [4:0] spi_oe,
  input logic [4:0] spi_out,
  input logic [4:0] spi_in,
  input logic [4:0] aud0_oe,
  input logic [4:0] aud0_in,
  input logic [1:0] aud1_in,
  input logic [4:0] pad_in,
  input logic [4:0] pad_oe,
  input logic [4:0] pad_out,
  input logic [4:0] conflict
);
  AST_INPUT_BROADCAST: assert property (@(posedge clk) disable iff (rst)
    (aud0_in == pad_in) && (aud1_in == pad_in[4:3])); // R4

  AST_AUDIO_LOW_PADS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (aud0_oe[2:0] & ~pad_oe[2:0]) == 3'b000); // R2

  AST_SPI_CLOCK_WINS: assert property (@(posedge clk) disable iff (rst)
    (spi_oe[2] && mode < 3'd4) |-> (pad_oe[2] && pad_out[2] == spi_out[2])); // R3

  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (rst)
    (pad_oe == 5'b0) |-> (pad_out == 5'b0)); // R3

  AST_SPI_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode > 3'd3) |-> (spi_in == 5'b00011)); // R6

  AST_CFG_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && !cfg_wr_addr) |=> (mode == $past(cfg_wr_data[2:0]))); // R9

  AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(cfg_wr_en && cfg_wr_addr) |=> ((conflict & $past(conflict)) == $past(conflict))); // R8

  AST_CONFLICT_SETS: assert property (@(posedge clk) disable iff (rst)
    (spi_oe[2] && aud0_oe[2] && mode < 3'd4) |=> conflict[2]); // R8
endmodule

bind pinmux_shared_pins pinmux_shared_pins_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
  .cfg_wr_data(cfg_wr_data), .mode(cfg_mode), .spi_oe(spi_oe), .spi_out(spi_out),
  .spi_in(spi_in), .aud0_oe(aud0_oe), .aud0_in(aud0_in), .aud1_in(aud1_in),
  .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .conflict(conflict)
);

// File: tb/pinmux_shared_pins_bench.sv
`timescale 1ns/1ps
module pinmux_shared_pins_bench;
  logic clk = 0;
  logic rst;
  logic cfg_wr_en, cfg_wr_addr;
  logic [4:0] cfg_wr_data;
  logic [4:0] spi_oe, spi_out, spi_in, aud0_oe, aud0_out, aud0_in, pad_in, pad_oe, pad_out, conflict;
  logic [1:0] aud1_oe, aud1_out, aud1_in;
  logic [4:0] aud0_width, aud1_width;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_mode;
  logic [1:0] m_own;
  logic [4:0] m_conf;

  always #5 clk = ~clk;

  pinmux_shared_pins u_pinmux_shared_pins (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .spi_oe(spi_oe), .spi_out(spi_out), .spi_in(spi_in),
    .aud0_oe(aud0_oe), .aud0_out(aud0_out), .aud0_in(aud0_in),
    .aud1_oe(aud1_oe), .aud1_out(aud1_out), .aud1_in(aud1_in),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .conflict(conflict),
    .aud0_width(aud0_width), .aud1_width(aud1_width)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic bit spi_has(input int mode, input int p);
    case (mode)
      0: return 1;
      1: return p != 1;
      2: return p != 0;
      3: return p >= 2;
      default: return 0;
    endcase
  endfunction

  // expected resolution, computed pad by pad
  logic [4:0] e_oe, e_out, e_spi_in, e_hit;
  int e_w0, e_w1;

  task automatic model_eval();
    bit off;
    off = (m_mode > 3);
    e_w0 = 11; e_w1 = 4;
    for (int p = 0; p < 5; p++) begin
      int n;
      bit s, a, b;
      s = spi_oe[p] && spi_has(m_mode, p);
      a = aud0_oe[p];
      b = 0;
      if (p >= 3) begin
        b = aud1_oe[p-3];
        if (off && m_own[p-3]) a = 0;
        if (off && !m_own[p-3]) b = 0;
      end
      n = int'(s) + int'(a) + int'(b);
      e_oe[p]  = (n > 0);
      e_hit[p] = (n > 1);
      e_out[p] = s ? spi_out[p] : a ? aud0_out[p] : b ? aud1_out[p-3] : 1'b0;
      if (spi_has(m_mode, p)) e_spi_in[p] = pad_in[p];
      else e_spi_in[p] = (p < 2);
      if (p < 3 && !spi_has(m_mode, p)) e_w0++;
    end
    if (off) begin
      for (int d = 0; d < 2; d++) begin
        if (m_own[d]) e_w1++;
        else e_w0++;
      end
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    model_eval();
    chk("R2 R7 pad_oe", 32'(pad_oe), 32'(e_oe));
    chk("R3 R7 pad_out", 32'(pad_out), 32'(e_out));
    chk("R5 R6 spi_in", 32'(spi_in), 32'(e_spi_in));
    chk("R4 aud_in", 32'({aud1_in, aud0_in}), 32'({pad_in[4:3], pad_in}));
    chk("R8 conflict", 32'(conflict), 32'(m_conf));
    chk("R9 R10 widths", 32'({aud0_width, aud1_width}), 32'({5'(e_w0), 5'(e_w1)}));
    @(posedge clk);
    if (rst) begin
      m_mode = 4; m_own = 0; m_conf = 0;
    end else begin
      if (cfg_wr_en && cfg_wr_addr) m_conf = (m_conf & ~cfg_wr_data) | e_hit;
      else m_conf = m_conf | e_hit;
      if (cfg_wr_en && !cfg_wr_addr) begin
        m_mode = int'(cfg_wr_data[2:0]);
        m_own  = cfg_wr_data[4:3];
      end
    end
    #1;
  endtask

  task automatic rand_pins();
    for (int p = 0; p < 5; p++) begin
      spi_oe[p]  = ($urandom % 3) == 0;
      aud0_oe[p] = ($urandom % 3) == 0;
    end
    aud1_oe  = {($urandom % 2) == 0, ($urandom % 2) == 0};
    spi_out  = 5'($urandom);
    aud0_out = 5'($urandom);
    aud1_out = 2'($urandom);
    pad_in   = 5'($urandom);
  endtask

  initial begin
    rst = 1; cfg_wr_en = 0; cfg_wr_addr = 0; cfg_wr_data = 0;
    spi_oe = '1; spi_out = '1; aud0_oe = 0; aud0_out = 0; aud1_oe = 0; aud1_out = 0; pad_in = 5'b10101;
    m_mode = 4; m_own = 0; m_conf = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset values visible at the ports
    @(negedge clk);
    chk("R1 conflict", 32'(conflict), 32'd0);
    chk("R1 aud0_width", 32'(aud0_width), 32'd16);
    chk("R1 aud1_width", 32'(aud1_width), 32'd4);
    chk("R1 R6 spi_in idle", 32'(spi_in), 32'(5'b00011));
    chk("R1 R6 spi enables ignored", 32'(pad_oe), 32'd0);
    @(posedge clk); #1;

    for (int md = 0; md < 8; md++) begin
      for (int ow = 0; ow < 4; ow++) begin
        rand_pins();
        cfg_wr_en = 1; cfg_wr_addr = 0; cfg_wr_data = 5'((ow << 3) | md);
        cycle();
        cfg_wr_en = 0;
        for (int k = 0; k < 40; k++) begin
          rand_pins();
          if (($urandom % 4) == 0) begin
            cfg_wr_en = 1; cfg_wr_addr = 1; cfg_wr_data = 5'($urandom);
          end else begin
            cfg_wr_en = 0;
          end
          cycle();
        end
        cfg_wr_en = 0;
      end
    end

    // R8: every source on pad 3 in mode 0 while clearing it; the set must win
    cfg_wr_en = 1; cfg_wr_addr = 0; cfg_wr_data = 5'd0;
    cycle();
    spi_oe = 5'b01000; aud0_oe = 5'b01000; aud1_oe = 2'b01;
    spi_out = 5'b01000; aud0_out = 0; aud1_out = 0;
    cfg_wr_en = 1; cfg_wr_addr = 1; cfg_wr_data = 5'b11111;
    cycle();
    cfg_wr_en = 0; spi_oe = 0; aud0_oe = 0; aud1_oe = 0;
    @(negedge clk);
    chk("R8 set wins over clear", 32'(conflict), 32'(5'b01000));
    @(posedge clk); #1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule